// File: doc/BRIEF.md
# Configurable Fault Reaction Resolver

This block sits between a supply-rail monitor and a power state machine. Each monitored rail delivers one-cycle pulses that mark an already qualified undervoltage, overvoltage or overvoltage-protection fault. The block maps every pulse to a reaction chosen by that rail's own enable bits, which arrive as inputs from register storage. A reaction is one of four power-state requests: none, SAFE, RESET or OFF. The block also sets the levels of an active-low system reset output and an active-low driver-enable/interrupt output.

Faults that arrive together are merged by priority. The winning request is held until the state machine acknowledges it. A more severe fault that arrives later raises the held request. A less severe fault never lowers it. Some faults change no state and only pull the interrupt output low. That interrupt-only condition is also held until the acknowledge.

Top module: `fault_reaction_resolver`

## Requirements
- R1: After reset `req_o` is 0 and both `sys_reset_n_o` and `drv_irq_n_o` are 1. `req_o` encodes none=0, SAFE=1, RESET=2, OFF=3. Results appear on the outputs one clock after the fault pulse is sampled. `sys_reset_n_o` is 0 exactly when the held request is RESET or OFF. `drv_irq_n_o` is 0 when the held request is not none or when an interrupt-only condition is held.
- R2: A battery undervoltage pulse never changes `req_o` or `sys_reset_n_o`. It pulls `drv_irq_n_o` low only when `lowin_irq_en_i` is 1.
- R3: A battery overvoltage pulse requests OFF.
- R4: A regulator-1 undervoltage or overvoltage pulse requests RESET when the matching reset enable is 1, and SAFE when it is 0.
- R5: A regulator-2 undervoltage pulse requests RESET when its reset enable is 1. When that enable is 0, it leaves `req_o` at none but pulls `drv_irq_n_o` low. A boost undervoltage pulse requests RESET when its reset enable is 1. When that enable is 0, it has no effect on any output.
- R6: A regulator-2 or boost overvoltage pulse requests RESET when the matching reset enable is 1, and SAFE when it is 0.
- R7: A regulator-1 overvoltage-protection pulse requests OFF when `r1_ovp_off_en_i` is 1, and SAFE when it is 0. Regulator-2 and boost overvoltage-protection pulses always request SAFE.
- R8: An external-rail (index g) undervoltage or overvoltage pulse requests RESET when the matching reset enable bit g is 1. When that bit is 0, it requests SAFE if the matching interrupt enable bit g is 1. If both bits are 0, the pulse has no effect on any output.
- R9: An internal-regulator undervoltage or overvoltage pulse always requests OFF.
- R10: Pulses in the same cycle resolve to the most severe request, with OFF > RESET > SAFE > none.
- R11: Without an acknowledge, the held request never decreases. A later more severe fault raises it, and a less severe fault leaves it unchanged.
- R12: `ack_i` replaces the held request and the interrupt-only condition with whatever the same cycle's pulses produce. With no pulses, this returns the block to the R1 reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | State machine acknowledge of held request |
| bat_uv_i | input | 1 | Battery undervoltage pulse |
| bat_ov_i | input | 1 | Battery overvoltage pulse |
| r1_uv_i | input | 1 | Regulator-1 undervoltage pulse |
| r1_ov_i | input | 1 | Regulator-1 overvoltage pulse |
| r1_ovp_i | input | 1 | Regulator-1 overvoltage-protection pulse |
| r2_uv_i | input | 1 | Regulator-2 undervoltage pulse |
| r2_ov_i | input | 1 | Regulator-2 overvoltage pulse |
| r2_ovp_i | input | 1 | Regulator-2 overvoltage-protection pulse |
| bst_uv_i | input | 1 | Boost undervoltage pulse |
| bst_ov_i | input | 1 | Boost overvoltage pulse |
| bst_ovp_i | input | 1 | Boost overvoltage-protection pulse |
| ext_uv_i | input | N_EXT | External-rail undervoltage pulses |
| ext_ov_i | input | N_EXT | External-rail overvoltage pulses |
| ireg_uv_i | input | 1 | Internal-regulator undervoltage pulse |
| ireg_ov_i | input | 1 | Internal-regulator overvoltage pulse |
| lowin_irq_en_i | input | 1 | Interrupt enable for battery undervoltage |
| r1_uv_rst_en_i | input | 1 | Regulator-1 undervoltage reset enable |
| r1_ov_rst_en_i | input | 1 | Regulator-1 overvoltage reset enable |
| r1_ovp_off_en_i | input | 1 | Regulator-1 protection off enable |
| r2_uv_rst_en_i | input | 1 | Regulator-2 undervoltage reset enable |
| r2_ov_rst_en_i | input | 1 | Regulator-2 overvoltage reset enable |
| bst_uv_rst_en_i | input | 1 | Boost undervoltage reset enable |
| bst_ov_rst_en_i | input | 1 | Boost overvoltage reset enable |
| ext_uv_rst_en_i | input | N_EXT | External undervoltage reset enables |
| ext_uv_irq_en_i | input | N_EXT | External undervoltage interrupt enables |
| ext_ov_rst_en_i | input | N_EXT | External overvoltage reset enables |
| ext_ov_irq_en_i | input | N_EXT | External overvoltage interrupt enables |
| req_o | output | 2 | Held power-state request |
| sys_reset_n_o | output | 1 | Active-low system reset level |
| drv_irq_n_o | output | 1 | Active-low driver-enable/interrupt level |

## Verification
The embedded assertions check four things on every cycle. The held request never drops without an acknowledge. An acknowledge with no fault pulses clears everything. Battery overvoltage and internal-regulator faults always yield OFF. An enabled regulator-1 protection fault yields OFF. The per-rail mapping from each enable setting to a request needs the bench's directed scenarios, because it depends on combinations of inputs. The same holds for the interrupt-only effects, for external faults that are ignored, for priority among simultaneous pulses, and for a fault that coincides with an acknowledge.

// File: rtl/fault_reaction_resolver.sv
module fault_reaction_resolver #(
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic             bat_uv_i,
  input  logic             bat_ov_i,
  input  logic             r1_uv_i,
  input  logic             r1_ov_i,
  input  logic             r1_ovp_i,
  input  logic             r2_uv_i,
  input  logic             r2_ov_i,
  input  logic             r2_ovp_i,
  input  logic             bst_uv_i,
  input  logic             bst_ov_i,
  input  logic             bst_ovp_i,
  input  logic [N_EXT-1:0] ext_uv_i,
  input  logic [N_EXT-1:0] ext_ov_i,
  input  logic             ireg_uv_i,
  input  logic             ireg_ov_i,
  input  logic             lowin_irq_en_i,
  input  logic             r1_uv_rst_en_i,
  input  logic             r1_ov_rst_en_i,
  input  logic             r1_ovp_off_en_i,
  input  logic             r2_uv_rst_en_i,
  input  logic             r2_ov_rst_en_i,
  input  logic             bst_uv_rst_en_i,
  input  logic             bst_ov_rst_en_i,
  input  logic [N_EXT-1:0] ext_uv_rst_en_i,
  input  logic [N_EXT-1:0] ext_uv_irq_en_i,
  input  logic [N_EXT-1:0] ext_ov_rst_en_i,
  input  logic [N_EXT-1:0] ext_ov_irq_en_i,
  output logic [1:0]       req_o,
  output logic             sys_reset_n_o,
  output logic             drv_irq_n_o
);

  localparam logic [1:0] RQ_NONE  = 2'd0;
  localparam logic [1:0] RQ_SAFE  = 2'd1;
  localparam logic [1:0] RQ_RESET = 2'd2;
  localparam logic [1:0] RQ_OFF   = 2'd3;
  localparam int N_FIX = 12;
  localparam int N_SRC = N_FIX + 2 * N_EXT;

  logic [1:0] src [N_SRC];
  logic [1:0] new_req;
  logic       new_irq;
  logic [1:0] req_q;
  logic       irq_q;

  assign src[0]  = bat_ov_i  ? RQ_OFF : RQ_NONE;
  assign src[1]  = r1_uv_i   ? (r1_uv_rst_en_i  ? RQ_RESET : RQ_SAFE) : RQ_NONE;
  assign src[2]  = r1_ov_i   ? (r1_ov_rst_en_i  ? RQ_RESET : RQ_SAFE) : RQ_NONE;
  assign src[3]  = r1_ovp_i  ? (r1_ovp_off_en_i ? RQ_OFF   : RQ_SAFE) : RQ_NONE;
  assign src[4]  = (r2_uv_i && r2_uv_rst_en_i) ? RQ_RESET : RQ_NONE;
  assign src[5]  = r2_ov_i   ? (r2_ov_rst_en_i  ? RQ_RESET : RQ_SAFE) : RQ_NONE;
  assign src[6]  = r2_ovp_i  ? RQ_SAFE : RQ_NONE;
  assign src[7]  = (bst_uv_i && bst_uv_rst_en_i) ? RQ_RESET : RQ_NONE;
  assign src[8]  = bst_ov_i  ? (bst_ov_rst_en_i ? RQ_RESET : RQ_SAFE) : RQ_NONE;
  assign src[9]  = bst_ovp_i ? RQ_SAFE : RQ_NONE;
  assign src[10] = ireg_uv_i ? RQ_OFF : RQ_NONE;
  assign src[11] = ireg_ov_i ? RQ_OFF : RQ_NONE;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign src[N_FIX + 2*g]     = !ext_uv_i[g]      ? RQ_NONE  :
                                  ext_uv_rst_en_i[g] ? RQ_RESET :
                                  ext_uv_irq_en_i[g] ? RQ_SAFE  : RQ_NONE;
    assign src[N_FIX + 2*g + 1] = !ext_ov_i[g]      ? RQ_NONE  :
                                  ext_ov_rst_en_i[g] ? RQ_RESET :
                                  ext_ov_irq_en_i[g] ? RQ_SAFE  : RQ_NONE;
  end

  always_comb begin
    new_req = RQ_NONE;
    for (int i = 0; i < N_SRC; i++)
      if (src[i] > new_req) new_req = src[i];
  end

  assign new_irq = (bat_uv_i && lowin_irq_en_i) || (r2_uv_i && !r2_uv_rst_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= RQ_NONE;
      irq_q <= 1'b0;
    end else if (ack_i) begin
      req_q <= new_req;
      irq_q <= new_irq;
    end else begin
      if (new_req > req_q) req_q <= new_req;
      irq_q <= irq_q | new_irq;
    end
  end

  assign req_o         = req_q;
  assign sys_reset_n_o = !req_q[1];
  assign drv_irq_n_o   = !((req_q != RQ_NONE) || irq_q);

  AST_NO_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> req_o >= $past(req_o)); // R11

  AST_ACK_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && new_req == RQ_NONE && !new_irq) |=> (req_o == RQ_NONE && sys_reset_n_o && drv_irq_n_o)); // R12

  AST_BAT_OV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bat_ov_i |=> (req_o == RQ_OFF && !sys_reset_n_o && !drv_irq_n_o)); // R3

  AST_IREG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ireg_uv_i || ireg_ov_i) |=> req_o == RQ_OFF); // R9

  AST_R1_OVP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (r1_ovp_i && r1_ovp_off_en_i) |=> (req_o == RQ_OFF && !sys_reset_n_o)); // R7

endmodule

// File: tb/fault_reaction_resolver_bench.sv
module fault_reaction_resolver_bench;
  localparam int NE = 2;

  logic clk = 0, rst_n = 0, ack = 0;
  logic bat_uv = 0, bat_ov = 0, r1_uv = 0, r1_ov = 0, r1_ovp = 0;
  logic r2_uv = 0, r2_ov = 0, r2_ovp = 0, bst_uv = 0, bst_ov = 0, bst_ovp = 0;
  logic [NE-1:0] ext_uv = '0, ext_ov = '0;
  logic ireg_uv = 0, ireg_ov = 0;
  logic lowin_en = 0, r1_uv_en = 0, r1_ov_en = 0, r1_off_en = 0;
  logic r2_uv_en = 0, r2_ov_en = 0, bst_uv_en = 0, bst_ov_en = 0;
  logic [NE-1:0] ext_uv_rst = '0, ext_uv_irq = '0, ext_ov_rst = '0, ext_ov_irq = '0;
  logic [1:0] req;
  logic sys_rst_n, drv_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_reaction_resolver #(.N_EXT(NE)) u_fault_reaction_resolver (
    .clk(clk), .rst_n(rst_n), .ack_i(ack),
    .bat_uv_i(bat_uv), .bat_ov_i(bat_ov), .r1_uv_i(r1_uv), .r1_ov_i(r1_ov), .r1_ovp_i(r1_ovp),
    .r2_uv_i(r2_uv), .r2_ov_i(r2_ov), .r2_ovp_i(r2_ovp),
    .bst_uv_i(bst_uv), .bst_ov_i(bst_ov), .bst_ovp_i(bst_ovp),
    .ext_uv_i(ext_uv), .ext_ov_i(ext_ov), .ireg_uv_i(ireg_uv), .ireg_ov_i(ireg_ov),
    .lowin_irq_en_i(lowin_en), .r1_uv_rst_en_i(r1_uv_en), .r1_ov_rst_en_i(r1_ov_en),
    .r1_ovp_off_en_i(r1_off_en), .r2_uv_rst_en_i(r2_uv_en), .r2_ov_rst_en_i(r2_ov_en),
    .bst_uv_rst_en_i(bst_uv_en), .bst_ov_rst_en_i(bst_ov_en),
    .ext_uv_rst_en_i(ext_uv_rst), .ext_uv_irq_en_i(ext_uv_irq),
    .ext_ov_rst_en_i(ext_ov_rst), .ext_ov_irq_en_i(ext_ov_irq),
    .req_o(req), .sys_reset_n_o(sys_rst_n), .drv_irq_n_o(drv_n));

  // expected reset/irq levels follow the R1 mapping
  task automatic chk(string tag, logic [1:0] er, logic ed);
    logic es;
    es = !er[1];
    n_chk++;
    if (req !== er || sys_rst_n !== es || drv_n !== ed) begin
      n_bad++;
      $display("FAIL %s: req=%0d rst_n=%0b drv_n=%0b expected req=%0d rst_n=%0b drv_n=%0b",
               tag, req, sys_rst_n, drv_n, er, es, ed);
    end
  endtask

  task automatic clr_pulses();
    bat_uv = 0; bat_ov = 0; r1_uv = 0; r1_ov = 0; r1_ovp = 0;
    r2_uv = 0; r2_ov = 0; r2_ovp = 0; bst_uv = 0; bst_ov = 0; bst_ovp = 0;
    ext_uv = '0; ext_ov = '0; ireg_uv = 0; ireg_ov = 0; ack = 0;
  endtask

  task automatic fire();
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic do_ack();
    ack = 1;
    fire();
  endtask

  task automatic t_reset();
    chk("R1 reset state", 2'd0, 1);
  endtask

  task automatic t_battery();
    lowin_en = 0; bat_uv = 1; fire(); chk("R2 bat uv irq off", 2'd0, 1);
    lowin_en = 1; bat_uv = 1; fire(); chk("R2 bat uv irq on", 2'd0, 0);
    do_ack(); chk("R12 ack clears irq", 2'd0, 1);
    bat_ov = 1; fire(); chk("R3 bat ov", 2'd3, 0);
    do_ack();
  endtask

  task automatic t_reg1();
    r1_uv_en = 1; r1_uv = 1; fire(); chk("R4 r1 uv rst_en", 2'd2, 0); do_ack();
    r1_uv_en = 0; r1_uv = 1; fire(); chk("R4 r1 uv safe", 2'd1, 0); do_ack();
    r1_ov_en = 1; r1_ov = 1; fire(); chk("R4 r1 ov rst_en", 2'd2, 0); do_ack();
    r1_ov_en = 0; r1_ov = 1; fire(); chk("R4 r1 ov safe", 2'd1, 0); do_ack();
  endtask

  task automatic t_uv_other();
    r2_uv_en = 0; r2_uv = 1; fire(); chk("R5 r2 uv irq only", 2'd0, 0); do_ack();
    r2_uv_en = 1; r2_uv = 1; fire(); chk("R5 r2 uv reset", 2'd2, 0); do_ack();
    bst_uv_en = 0; bst_uv = 1; fire(); chk("R5 bst uv no effect", 2'd0, 1); do_ack();
    bst_uv_en = 1; bst_uv = 1; fire(); chk("R5 bst uv reset", 2'd2, 0); do_ack();
  endtask

  task automatic t_ov_other();
    r2_ov_en = 0; r2_ov = 1; fire(); chk("R6 r2 ov safe", 2'd1, 0); do_ack();
    r2_ov_en = 1; r2_ov = 1; fire(); chk("R6 r2 ov reset", 2'd2, 0); do_ack();
    bst_ov_en = 0; bst_ov = 1; fire(); chk("R6 bst ov safe", 2'd1, 0); do_ack();
    bst_ov_en = 1; bst_ov = 1; fire(); chk("R6 bst ov reset", 2'd2, 0); do_ack();
  endtask

  task automatic t_ovp();
    r1_off_en = 1; r1_ovp = 1; fire(); chk("R7 r1 ovp off", 2'd3, 0); do_ack();
    r1_off_en = 0; r1_ovp = 1; fire(); chk("R7 r1 ovp safe", 2'd1, 0); do_ack();
    r2_ovp = 1; fire(); chk("R7 r2 ovp safe", 2'd1, 0); do_ack();
    bst_ovp = 1; fire(); chk("R7 bst ovp safe", 2'd1, 0); do_ack();
  endtask

  task automatic t_ext();
    for (int g = 0; g < NE; g++) begin
      ext_uv_rst = '0; ext_uv_irq = '0; ext_ov_rst = '0; ext_ov_irq = '0;
      ext_uv_rst[g] = 1; ext_uv[g] = 1; fire(); chk("R8 ext uv reset", 2'd2, 0); do_ack();
      ext_uv_rst[g] = 0; ext_uv_irq[g] = 1; ext_uv[g] = 1; fire(); chk("R8 ext uv safe", 2'd1, 0); do_ack();
      ext_uv_irq[g] = 0; ext_uv[g] = 1; fire(); chk("R8 ext uv ignored", 2'd0, 1); do_ack();
      ext_ov_rst[g] = 1; ext_ov[g] = 1; fire(); chk("R8 ext ov reset", 2'd2, 0); do_ack();
      ext_ov_rst[g] = 0; ext_ov_irq[g] = 1; ext_ov[g] = 1; fire(); chk("R8 ext ov safe", 2'd1, 0); do_ack();
      ext_ov_irq[g] = 0; ext_ov[g] = 1; fire(); chk("R8 ext ov ignored", 2'd0, 1); do_ack();
    end
    ext_uv_rst = '0; ext_uv_irq = '0; ext_ov_rst = '0; ext_ov_irq = '0;
  endtask

  task automatic t_ireg();
    ireg_uv = 1; fire(); chk("R9 ireg uv off", 2'd3, 0); do_ack();
    ireg_ov = 1; fire(); chk("R9 ireg ov off", 2'd3, 0); do_ack();
  endtask

  task automatic t_prio();
    r1_uv_en = 0; ext_uv_rst[0] = 1;
    r1_uv = 1; ext_uv[0] = 1; fire(); chk("R10 reset over safe", 2'd2, 0); do_ack();
    r1_uv = 1; ext_uv[0] = 1; bat_ov = 1; fire(); chk("R10 off over reset", 2'd3, 0); do_ack();
    ext_uv_rst = '0;
  endtask

  task automatic t_latch();
    r2_ovp = 1; fire(); chk("R11 safe held", 2'd1, 0);
    repeat (3) @(negedge clk);
    chk("R11 safe still held", 2'd1, 0);
    r1_ov_en = 1; r1_ov = 1; fire(); chk("R11 upgrade to reset", 2'd2, 0);
    bst_ovp = 1; fire(); chk("R11 no downgrade", 2'd2, 0);
    do_ack(); chk("R12 ack clears", 2'd0, 1);
  endtask

  task automatic t_ack_coincide();
    bat_ov = 1; fire(); chk("R12 setup off", 2'd3, 0);
    ack = 1; r2_ovp = 1; fire(); chk("R12 ack with safe fault", 2'd1, 0);
    ack = 1; r1_ov_en = 1; r1_ov = 1; fire(); chk("R12 ack with reset fault", 2'd2, 0);
    ack = 1; lowin_en = 1; bat_uv = 1; fire(); chk("R12 ack with irq fault", 2'd0, 0);
    do_ack(); chk("R12 ack idle", 2'd0, 1);
  endtask

  initial begin
    #1;
    chk("R1 in reset", 2'd0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_battery();
    t_reg1();
    t_uv_other();
    t_ov_other();
    t_ovp();
    t_ext();
    t_ireg();
    t_prio();
    t_latch();
    t_ack_coincide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule